// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one memory request from a group of 32 lanes and turns it into the smallest set of bus transactions that serves it. A request carries one byte address per lane, a mask of the lanes that take part, and a mode bit. The mode bit picks the fetch size. In caching mode every transaction moves an aligned 128-byte line. In non-caching mode every transaction moves an aligned 32-byte segment. Every lane access is one 4-byte word, and lane addresses are assumed to be word aligned.

After a request is accepted, the block works out which aligned regions the active lanes fall into. It emits one transaction per distinct region, at most one per cycle, over a valid/ready handshake. The regions go out lowest address first. Each transaction carries the mask of the lanes whose word lies inside that region. When the last transaction has been handed off, the block pulses a completion flag. With that flag it reports how many transactions it issued and how many bytes they moved, so bus utilization can be read off as useful bytes over moved bytes. A request with no active lanes issues nothing and still completes.

Top module: `warp_coalescer`

## Requirements
- R1: `req_ready` is high only while no request is in flight. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from that point through the cycle in which `done` is high, and returns high on the next cycle.
- R2: With `req_uncached` = 0, each transaction address is a multiple of 128 and `txn_bytes` = 128. With `req_uncached` = 1, each address is a multiple of 32 and `txn_bytes` = 32.
- R3: The number of transactions equals the number of distinct aligned regions touched by active lanes. For 32 aligned, consecutive words (in any lane order) this is 1 line or 4 segments. For a misaligned consecutive run it is 2 lines or at most 5 segments. For a broadcast of one word it is 1 in either mode. `done_count` reports this number.
- R4: Within one request, transactions appear in strictly ascending address order.
- R5: Bit i of `txn_lanes` is set exactly when lane i is active and its address lies inside that transaction's region. Over one request the lane masks are disjoint, and their union equals the active mask.
- R6: Inactive lanes never affect a transaction. A request with an all-zero mask produces no transaction and raises `done` on the second cycle after acceptance, with `done_count` = 0 and `done_bytes` = 0.
- R7: On the `done` cycle, `done_bytes` equals `done_count` times the granularity of the request's mode.
- R8: While `txn_valid` is high and `txn_ready` is low, the next cycle still has `txn_valid` high with the same `txn_addr` and `txn_lanes`. With `txn_ready` held high, one transaction is handed off per cycle.
- R9: After reset, `req_ready` = 1, `txn_valid` = 0 and `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 1024 | Lane byte addresses, lane i at bits [32*i +: 32] |
| req_mask | input | 32 | Active lanes, bit i = lane i |
| req_uncached | input | 1 | 1 = 32-byte segments, 0 = 128-byte lines |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Bus takes the transaction |
| txn_addr | output | 32 | Aligned base address of the region |
| txn_lanes | output | 32 | Lanes served by this transaction |
| txn_bytes | output | 8 | Bytes moved by this transaction |
| txn_last | output | 1 | This is the final transaction of the request |
| done | output | 1 | One-cycle pulse, request complete |
| done_count | output | 6 | Transactions issued for the request |
| done_bytes | output | 13 | Bytes moved for the request |

## Verification
The coalescing function is driven with aligned consecutive runs, lane-permuted runs, runs shifted off alignment by one word, broadcasts of a single word, an empty mask, a sparse mask, and random scatter over a 4 KB window, each in both modes. Aligned and permuted runs show that lane order does not change the grouping. The shifted runs separate line from segment counting at the region edges. Broadcasts and the empty mask show the one-transaction and zero-transaction extremes. Random scatter with a random ready pattern tests ordering, lane-mask partitioning and stall holding when many distinct regions mix together.

// File: rtl/coal_pkg.sv
// Shared definitions for the warp coalescer.
// Assumes: nothing beyond the standard language.
package coal_pkg;

    // Request-level sequencing states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } coal_state_e;

endpackage

// File: rtl/lane_tag_unit.sv
// Converts every lane address into a region tag (address shifted right by
// the granularity of the selected mode). Tags of both modes share one width
// so that a single comparator tree serves either mode.
// Assumes: LINE_SHIFT >= SEG_SHIFT.
module lane_tag_unit #(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int SEG_SHIFT  = 5,
    parameter int LINE_SHIFT = 7,
    localparam int TAG_W     = ADDR_W - SEG_SHIFT
) (
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  logic                    uncached,
    output logic [LANES*TAG_W-1:0]  tag_flat
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ADDR_W-1:0] lane_addr;
        assign lane_addr = addr_flat[g*ADDR_W +: ADDR_W];
        // Pick the shift that matches the fetch size of the current mode
        always_comb begin
            if (uncached)
                tag_flat[g*TAG_W +: TAG_W] = TAG_W'(lane_addr >> SEG_SHIFT);
            else
                tag_flat[g*TAG_W +: TAG_W] = TAG_W'(lane_addr >> LINE_SHIFT);
        end
    end

endmodule

// File: rtl/region_min_tree.sv
// Balanced reduction tree that finds the smallest tag among lanes that are
// still waiting. Heap layout: node n has children 2n+1 and 2n+2, leaves sit
// at LANES-1 .. 2*LANES-2.
// Assumes: LANES is a power of two and at least 2.
module region_min_tree #(
    parameter int LANES = 32,
    parameter int TAG_W = 27,
    localparam int NODES = 2*LANES - 1
) (
    input  logic [LANES-1:0]       cand,
    input  logic [LANES*TAG_W-1:0] tag_flat,
    output logic [TAG_W-1:0]       min_tag,
    output logic                   any
);

    logic [NODES-1:0][TAG_W-1:0] node_tag;
    logic [NODES-1:0]            node_vld;

    for (genvar l = 0; l < LANES; l++) begin : g_leaf
        assign node_tag[LANES-1+l] = tag_flat[l*TAG_W +: TAG_W];
        assign node_vld[LANES-1+l] = cand[l];
    end

    for (genvar n = 0; n < LANES-1; n++) begin : g_node
        // Keep the valid child with the lower tag
        always_comb begin
            node_vld[n] = node_vld[2*n+1] | node_vld[2*n+2];
            if (!node_vld[2*n+2])
                node_tag[n] = node_tag[2*n+1];
            else if (!node_vld[2*n+1])
                node_tag[n] = node_tag[2*n+2];
            else if (node_tag[2*n+2] < node_tag[2*n+1])
                node_tag[n] = node_tag[2*n+2];
            else
                node_tag[n] = node_tag[2*n+1];
        end
    end

    assign min_tag = node_tag[0];
    assign any     = node_vld[0];

endmodule

// File: rtl/group_match.sv
// Marks every waiting lane whose tag equals the chosen region tag; these
// lanes are served by the transaction now on offer.
// Assumes: tags were produced under the same mode as min_tag.
module group_match #(
    parameter int LANES = 32,
    parameter int TAG_W = 27
) (
    input  logic [LANES-1:0]       cand,
    input  logic [LANES*TAG_W-1:0] tag_flat,
    input  logic [TAG_W-1:0]       min_tag,
    output logic [LANES-1:0]       group
);

    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign group[g] = cand[g] && (tag_flat[g*TAG_W +: TAG_W] == min_tag);
    end

endmodule

// File: rtl/coal_ctrl.sv
// Request sequencer: captures a request, retires one lane group per
// accepted transaction, counts transactions, and pulses done for one cycle.
// Assumes: group is a non-empty subset of pend_q whenever any is high.
module coal_ctrl
    import coal_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_mask,
    input  logic                    req_uncached,
    output logic                    req_ready,
    input  logic                    any,
    input  logic [LANES-1:0]        group,
    input  logic                    txn_ready,
    output logic [LANES*ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]        pend_q,
    output logic                    unc_q,
    output logic                    busy,
    output logic                    last,
    output logic                    done,
    output logic [CNT_W-1:0]        count_q
);

    coal_state_e      state_q;
    logic [LANES-1:0] remain;

    assign remain    = pend_q & ~group;
    assign last      = (remain == '0);
    assign req_ready = (state_q == ST_IDLE);
    assign busy      = (state_q == ST_BUSY);
    assign done      = (state_q == ST_DONE);

    // Request capture: address and mode are held for the whole request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            unc_q  <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid) begin
            addr_q <= req_addr;
            unc_q  <= req_uncached;
        end
    end

    // Sequencing of pending lanes, transaction count and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            count_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        pend_q  <= req_mask;
                        count_q <= '0;
                        state_q <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (!any) begin
                        state_q <= ST_DONE;
                    end else if (txn_ready) begin
                        pend_q  <= remain;
                        count_q <= count_q + 1'b1;
                        if (last)
                            state_q <= ST_DONE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/warp_coalescer.sv
// Warp memory access coalescer. Groups the active lanes of one 32-lane
// request by aligned region (128-byte line or 32-byte segment) and emits
// one transaction per region, lowest address first, one per cycle.
// Assumes: every lane address is word aligned and each access is 4 bytes.
module warp_coalescer #(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int SEG_BYTES  = 32,
    parameter int LINE_BYTES = 128,
    localparam int SEG_SHIFT  = $clog2(SEG_BYTES),
    localparam int LINE_SHIFT = $clog2(LINE_BYTES),
    localparam int TAG_W      = ADDR_W - SEG_SHIFT,
    localparam int CNT_W      = $clog2(LANES + 1),
    localparam int SZ_W       = $clog2(LINE_BYTES + 1),
    localparam int BYTES_W    = $clog2(LANES*LINE_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_mask,
    input  logic                    req_uncached,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_addr,
    output logic [LANES-1:0]        txn_lanes,
    output logic [SZ_W-1:0]         txn_bytes,
    output logic                    txn_last,
    output logic                    done,
    output logic [CNT_W-1:0]        done_count,
    output logic [BYTES_W-1:0]      done_bytes
);

    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES-1:0]        pend_q;
    logic                    unc_q;
    logic                    busy;
    logic                    any;
    logic                    last;
    logic [LANES-1:0]        group;
    logic [TAG_W-1:0]        min_tag;
    logic [LANES*TAG_W-1:0]  tag_flat;
    logic [CNT_W-1:0]        count_q;

    lane_tag_unit #(
        .LANES(LANES), .ADDR_W(ADDR_W),
        .SEG_SHIFT(SEG_SHIFT), .LINE_SHIFT(LINE_SHIFT)
    ) tag_i (
        .addr_flat(addr_q), .uncached(unc_q), .tag_flat(tag_flat)
    );

    region_min_tree #(.LANES(LANES), .TAG_W(TAG_W)) tree_i (
        .cand(pend_q), .tag_flat(tag_flat), .min_tag(min_tag), .any(any)
    );

    group_match #(.LANES(LANES), .TAG_W(TAG_W)) match_i (
        .cand(pend_q), .tag_flat(tag_flat), .min_tag(min_tag), .group(group)
    );

    coal_ctrl #(.LANES(LANES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_mask(req_mask),
        .req_uncached(req_uncached), .req_ready(req_ready),
        .any(any), .group(group), .txn_ready(txn_ready),
        .addr_q(addr_q), .pend_q(pend_q), .unc_q(unc_q),
        .busy(busy), .last(last), .done(done), .count_q(count_q)
    );

    // Transaction fields: region base rebuilt from the tag in the held mode
    always_comb begin
        txn_valid = busy && any;
        txn_lanes = group;
        txn_last  = last;
        if (unc_q) begin
            txn_addr  = ADDR_W'(min_tag) << SEG_SHIFT;
            txn_bytes = SZ_W'(SEG_BYTES);
        end else begin
            txn_addr  = ADDR_W'(min_tag) << LINE_SHIFT;
            txn_bytes = SZ_W'(LINE_BYTES);
        end
    end

    // Completion report: count and bytes scaled by the held granularity
    always_comb begin
        done_count = count_q;
        if (unc_q)
            done_bytes = BYTES_W'(count_q) << SEG_SHIFT;
        else
            done_bytes = BYTES_W'(count_q) << LINE_SHIFT;
    end

endmodule

// File: rtl/coal_chk.sv
// Protocol and partition checker for warp_coalescer, bound to every
// instance. Tracks the lanes served and bytes moved within each request.
// Assumes: connected only to top-level ports.
module coal_chk #(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int SEG_BYTES  = 32,
    parameter int LINE_BYTES = 128,
    parameter int CNT_W      = 6,
    parameter int SZ_W       = 8,
    parameter int BYTES_W    = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [LANES-1:0]   req_mask,
    input logic               txn_valid,
    input logic               txn_ready,
    input logic [ADDR_W-1:0]  txn_addr,
    input logic [LANES-1:0]   txn_lanes,
    input logic [SZ_W-1:0]    txn_bytes,
    input logic               done,
    input logic [CNT_W-1:0]   done_count,
    input logic [BYTES_W-1:0] done_bytes
);

    logic [LANES-1:0]   act_mask;
    logic [LANES-1:0]   served;
    logic [ADDR_W-1:0]  prev_addr;
    logic               have_prev;
    logic [BYTES_W-1:0] byte_sum;
    logic [CNT_W-1:0]   txn_cnt;

    // Per-request bookkeeping from observed handshakes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mask  <= '0;
            served    <= '0;
            prev_addr <= '0;
            have_prev <= 1'b0;
            byte_sum  <= '0;
            txn_cnt   <= '0;
        end else if (req_valid && req_ready) begin
            act_mask  <= req_mask;
            served    <= '0;
            have_prev <= 1'b0;
            byte_sum  <= '0;
            txn_cnt   <= '0;
        end else if (txn_valid && txn_ready) begin
            served    <= served | txn_lanes;
            prev_addr <= txn_addr;
            have_prev <= 1'b1;
            byte_sum  <= byte_sum + BYTES_W'(txn_bytes);
            txn_cnt   <= txn_cnt + 1'b1;
        end
    end

    // R1
    busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid || done) |-> !req_ready);
    // R1
    reopen_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);
    // R2
    region_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_bytes == SZ_W'(SEG_BYTES) && (txn_addr % SEG_BYTES) == 0) ||
                       (txn_bytes == SZ_W'(LINE_BYTES) && (txn_addr % LINE_BYTES) == 0)));
    // R3
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> done_count == txn_cnt);
    // R4
    ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && have_prev) |-> txn_addr > prev_addr);
    // R5
    disjoint_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_lanes != '0 && (txn_lanes & served) == '0 &&
                       (txn_lanes & ~act_mask) == '0));
    // R5
    full_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> served == act_mask);
    // R7
    byte_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> done_bytes == byte_sum);
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr) && $stable(txn_lanes)));

endmodule

bind warp_coalescer coal_chk #(
    .LANES(LANES), .ADDR_W(ADDR_W), .SEG_BYTES(SEG_BYTES), .LINE_BYTES(LINE_BYTES),
    .CNT_W(CNT_W), .SZ_W(SZ_W), .BYTES_W(BYTES_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_addr(txn_addr), .txn_lanes(txn_lanes), .txn_bytes(txn_bytes),
    .done(done), .done_count(done_count), .done_bytes(done_bytes)
);

// File: tb/warp_coalescer_tb_top.sv
`timescale 1ns/1ps
module warp_coalescer_tb_top;

    localparam int LANES = 32;
    localparam int AW    = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [LANES*AW-1:0] req_addr = '0;
    logic [LANES-1:0]  req_mask = '0;
    logic              req_uncached = 1'b0;
    logic              txn_valid;
    logic              txn_ready = 1'b0;
    logic [AW-1:0]     txn_addr;
    logic [LANES-1:0]  txn_lanes;
    logic [7:0]        txn_bytes;
    logic              txn_last;
    logic              done;
    logic [5:0]        done_count;
    logic [12:0]       done_bytes;

    int checks = 0;
    int fails  = 0;
    logic [AW-1:0] lane_a [LANES];

    always #2.5 clk = ~clk;

    warp_coalescer dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask), .req_uncached(req_uncached),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_addr(txn_addr),
        .txn_lanes(txn_lanes), .txn_bytes(txn_bytes), .txn_last(txn_last),
        .done(done), .done_count(done_count), .done_bytes(done_bytes)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Distinct regions touched by active lanes
    function automatic int exp_regions(input logic [LANES-1:0] m, input int sh);
        int n = 0;
        for (int i = 0; i < LANES; i++) begin
            bit seen = 0;
            if (!m[i]) continue;
            for (int j = 0; j < i; j++)
                if (m[j] && (lane_a[j] >> sh) == (lane_a[i] >> sh)) seen = 1;
            if (!seen) n++;
        end
        return n;
    endfunction

    // Lanes that belong to the region starting at base
    function automatic logic [LANES-1:0] exp_lanes(input logic [LANES-1:0] m,
                                                  input logic [AW-1:0] base, input int sh);
        logic [LANES-1:0] r = '0;
        for (int i = 0; i < LANES; i++)
            r[i] = m[i] && ((lane_a[i] >> sh) == (base >> sh));
        return r;
    endfunction

    task automatic run_req(input logic unc, input logic [LANES-1:0] msk,
                           input int rdy_pct, input int exp_n);
        int sh = unc ? 5 : 7;
        int gran = unc ? 32 : 128;
        int n = 0;
        int model_n;
        bit got_done = 0;
        bit have_prev = 0;
        bit stalled = 0;
        logic [AW-1:0] prev = '0;
        logic [AW-1:0] st_addr = '0;
        logic [LANES-1:0] st_lanes = '0;
        logic [LANES-1:0] served = '0;
        model_n = exp_regions(msk, sh);
        if (exp_n >= 0) check(model_n == exp_n, "R3 directed count", model_n, exp_n);
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = lane_a[i];
        req_mask = msk;
        req_uncached = unc;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_mask = ~msk;
        for (int cyc = 0; cyc < 400 && !got_done; cyc++) begin
            txn_ready = ($urandom_range(99) < rdy_pct);
            #1;
            if (!got_done && req_ready)
                check(0, "R1 ready while busy", req_ready, 0);
            if (stalled) begin
                check(txn_valid && txn_addr == st_addr && txn_lanes == st_lanes,
                      "R8 stall hold", txn_addr, st_addr);
            end
            stalled = txn_valid && !txn_ready;
            st_addr = txn_addr;
            st_lanes = txn_lanes;
            if (txn_valid && txn_ready) begin
                logic [LANES-1:0] el = exp_lanes(msk, txn_addr, sh);
                check(txn_lanes == el, "R5 lane mask", txn_lanes, el);
                check(txn_bytes == gran[7:0] && (txn_addr % gran) == 0,
                      "R2 size and alignment", txn_addr, gran);
                if (have_prev) check(txn_addr > prev, "R4 ascending order", txn_addr, prev);
                check(txn_last == ((served | txn_lanes) == msk), "R5 last flag",
                      txn_last, (served | txn_lanes) == msk);
                served |= txn_lanes;
                prev = txn_addr;
                have_prev = 1;
                n++;
            end
            if (done) begin
                got_done = 1;
                check(done_count == model_n, "R3 done_count", done_count, model_n);
                check(n == model_n, "R3 transactions seen", n, model_n);
                check(done_bytes == model_n * gran, "R7 done_bytes", done_bytes, model_n * gran);
                check(served == msk, "R5 union of masks", served, msk);
            end
            @(negedge clk);
        end
        check(got_done, "R6 completion seen", got_done, 1);
        txn_ready = 1'b0;
        #1;
        check(req_ready == 1'b1, "R1 ready after done", req_ready, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0a1));
        repeat (3) @(negedge clk);
        #1;
        // R9 reset state
        check(req_ready == 1'b1 && txn_valid == 1'b0 && done == 1'b0, "R9 reset outputs",
              {req_ready, txn_valid, done}, 3'b100);
        rst_n = 1'b1;

        // Aligned consecutive: 1 line / 4 segments (R3)
        for (int i = 0; i < LANES; i++) lane_a[i] = 32'h1000 + 4*i;
        run_req(1'b0, '1, 100, 1);
        run_req(1'b1, '1, 100, 4);
        // Permuted within the aligned block (R3)
        for (int i = 0; i < LANES; i++) lane_a[i] = 32'h2000 + 4*((i*7 + 3) % LANES);
        run_req(1'b0, '1, 100, 1);
        run_req(1'b1, '1, 60, 4);
        // Misaligned by one word: 2 lines / 5 segments (R3)
        for (int i = 0; i < LANES; i++) lane_a[i] = 32'h3004 + 4*i;
        run_req(1'b0, '1, 100, 2);
        run_req(1'b1, '1, 50, 5);
        // Broadcast of one word: 1 transaction, 128 or 32 bytes (R3, R7)
        for (int i = 0; i < LANES; i++) lane_a[i] = 32'h4044;
        run_req(1'b0, '1, 100, 1);
        run_req(1'b1, '1, 100, 1);
        // Empty mask: no transaction, done with zero counts (R6)
        for (int i = 0; i < LANES; i++) lane_a[i] = 32'h5000 + 256*i;
        run_req(1'b0, '0, 100, 0);
        // Sparse mask on scattered lines: inactive lanes ignored (R6)
        run_req(1'b0, 32'h0000_0101, 100, 2);
        run_req(1'b1, 32'h8000_0001, 40, 2);
        // Constrained random scatter with random backpressure (R4, R5, R8)
        for (int t = 0; t < 60; t++) begin
            logic [AW-1:0] base = 32'h0001_0000 + ($urandom_range(255) << 12);
            for (int i = 0; i < LANES; i++) lane_a[i] = base + 4*$urandom_range(1023);
            run_req(1'($urandom_range(1)), $urandom, 30 + $urandom_range(70), -1);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule